// File: doc/BRIEF.md
# Programmable Interval Timer with Timestamp Capture

This block combines a down-counting interval timer with a free-running 64-bit time base. Software loads a reload value, then writes a control word that picks one-shot or periodic operation and starts the counter. When the count expires, a sticky tick flag is set and drives the interrupt line. In one-shot mode the counter then stops at zero. In periodic mode it reloads and keeps producing ticks at a fixed spacing.

The time base counts every clock cycle from reset. Because it is 64 bits wide, it does not wrap in practice. A 32-bit count at 50 MHz would wrap in under 86 seconds. An asynchronous event strobe, for example the end of a conversion, is synchronized and edge detected. The time value at that moment is then copied into a timestamp register. A valid flag stays set until software reads the upper timestamp word. A second event that arrives before that read sets an overrun flag and replaces the stored stamp with the newer one.

All registers sit behind a simple word interface with write and read strobes, a 3-bit address and combinational read data.

Top module: `interval_timer_ts`

## Requirements
- R1: Writing the control register (address 0) with bit 0 set loads the reload register (address 1) into the counter and starts it. The counter decreases by one each cycle, and the tick flag sets exactly N cycles after the write, where N is the reload value.
- R2: In one-shot mode (control bit 1 clear), the counter fires once, stops at zero, and clears the running bit (status bit 3). No further ticks occur.
- R3: In periodic mode (control bit 1 set), the counter reloads on expiry and sets the tick flag every N cycles.
- R4: A reload value of zero loads the all-ones count.
- R5: Writing the control register with bit 0 clear halts the counter. The count then holds its value and no tick occurs.
- R6: The tick flag (status bit 0) drives irq_o. It stays set until a one is written to status bit 0 (address 2). Writing a zero leaves it set.
- R7: The 64-bit time base starts at zero after reset and increments by one every cycle. Its low word is at address 6 and its high word at address 7.
- R8: A rising edge of evt_i, after a synchronizer of SYNC_STAGES flops, stores the time base into the stamp register (low word at address 4, high word at address 5). The stored value equals the time read in the cycle the strobe rose plus SYNC_STAGES. Holding the strobe high captures only once.
- R9: A capture sets the stamp-valid flag (status bit 1). A read strobe on address 5 clears it.
- R10: A capture while stamp-valid is set raises the overrun flag (status bit 2) and keeps the newer stamp. Writing a one to status bit 2 clears the overrun flag.
- R11: After reset, the counter, control, reload, status and time base are all zero, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used to acknowledge the stamp) |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| evt_i | input | 1 | Asynchronous event strobe |
| irq_o | output | 1 | Interrupt, level, equal to the tick flag |

## Verification
The counter is exercised with a short one-shot count, a periodic count observed over two periods, and a zero reload. These cases separate an off-by-one in expiry timing, a missing reload, and a missing zero substitution. A halt during periodic running shows that the count freezes rather than reloads. The event strobe is driven as a single rising edge, as a level held high, and as two captures with no read in between. These cases separate the synchronizer latency, a double capture on a level, and the overrun path.

// File: rtl/itmr_pkg.sv
// Package: register addresses and field positions shared by the timer.
// Assumes a 3-bit word address and a 32-bit data path.
package itmr_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD   = 3'd1;
    localparam logic [ADDR_W-1:0] A_STATUS   = 3'd2;
    localparam logic [ADDR_W-1:0] A_COUNT    = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAMP_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAMP_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_TIME_LO  = 3'd6;
    localparam logic [ADDR_W-1:0] A_TIME_HI  = 3'd7;
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_PER_BIT  = 1;
    localparam int ST_TICK_BIT   = 0;
    localparam int ST_VALID_BIT  = 1;
    localparam int ST_OVR_BIT    = 2;
    localparam int ST_RUN_BIT    = 3;
endpackage

// File: rtl/tmr_countdown.sv
// Module: down counter with one-shot / periodic expiry.
// Assumes load and halt are single-cycle strobes; load has priority.
// A zero reload value is replaced by the all-ones count.
module tmr_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             halt_i,
    input  logic             periodic_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] count_q;
    logic             run_q;
    logic [CNT_W-1:0] start_val;
    logic             fire;

    // Substitute the maximum count for a zero reload.
    always_comb start_val = (reload_i == '0) ? '1 : reload_i;

    // Expiry happens on the cycle the count would step from one to zero.
    always_comb fire = run_q && (count_q == CNT_W'(1));

    // Counter state: load, halt, expire or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (load_i) begin
            count_q <= start_val;
            run_q   <= 1'b1;
        end else if (halt_i) begin
            run_q   <= 1'b0;
        end else if (fire) begin
            if (periodic_i) begin
                count_q <= start_val;
            end else begin
                count_q <= '0;
                run_q   <= 1'b0;
            end
        end else if (run_q) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count_o   = count_q;
    assign running_o = run_q;
    assign expire_o  = fire;

    // R1: a start loads the (substituted) reload value and runs
    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> run_q && count_q == $past(start_val));
    // R2: one-shot expiry stops at zero
    assert_oneshot_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !periodic_i && !load_i && !halt_i |=> !run_q && count_q == '0);
    // R3: periodic expiry reloads and keeps running
    assert_periodic_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire && periodic_i && !load_i && !halt_i |=> run_q && count_q == $past(start_val));
    // R4: zero reload gives the all-ones count
    assert_zero_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && reload_i == '0 |=> count_q == '1);
    // R5: a stopped counter holds its value
    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q && !load_i |=> $stable(count_q));
endmodule

// File: rtl/tmr_timebase.sv
// Module: free-running wide time base.
// Assumes a width large enough that wrap is never reached in service.
module tmr_timebase #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] time_o
);
    logic [TIME_W-1:0] time_q;

    // Advance by one every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_q + 1'b1;
    end

    assign time_o = time_q;

    // R7: the time base advances by exactly one per cycle
    assert_time_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> time_q == $past(time_q) + 1'b1);
endmodule

// File: rtl/tmr_evt_capture.sv
// Module: synchronizes an asynchronous strobe, detects its rising edge
// and captures the time base, with valid and overrun tracking.
// Assumes ack_i pulses once per read of the upper stamp word.
module tmr_evt_capture #(
    parameter int TIME_W      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_async_i,
    input  logic [TIME_W-1:0] time_i,
    input  logic              ack_i,
    input  logic              ovr_clr_i,
    output logic [TIME_W-1:0] stamp_o,
    output logic              valid_o,
    output logic              overrun_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic [TIME_W-1:0]      stamp_q;
    logic                   valid_q;
    logic                   ovr_q;

    // Synchronizer chain, one flop per stage.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= evt_async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Delay of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb rise = sync_q[SYNC_STAGES-1] && !prev_q;

    // Stamp register, valid flag and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q <= '0;
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (rise) stamp_q <= time_i;
            if (rise)       valid_q <= 1'b1;
            else if (ack_i) valid_q <= 1'b0;
            if (rise && valid_q && !ack_i) ovr_q <= 1'b1;
            else if (ovr_clr_i)            ovr_q <= 1'b0;
        end
    end

    assign stamp_o   = stamp_q;
    assign valid_o   = valid_q;
    assign overrun_o = ovr_q;

    // R8: an edge stores the time base value of that cycle
    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> valid_q && stamp_q == $past(time_i));
    // R9: valid persists until acknowledged
    assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !ack_i |=> valid_q);
    // R10: capture over an unread stamp raises overrun
    assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise && valid_q && !ack_i |=> ovr_q);
endmodule

// File: rtl/interval_timer_ts.sv
// Module: interval timer with timestamp capture, register front end.
// Assumes TIME_W is twice DATA_W and CNT_W does not exceed DATA_W.
// Reads are combinational; rd_en only acknowledges the upper stamp word.
module interval_timer_ts
    import itmr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              evt_i,
    output logic              irq_o
);
    localparam int TIME_W = 2 * DATA_W;

    logic [CNT_W-1:0]  reload_q;
    logic              periodic_q;
    logic              tick_q;
    logic              ctrl_wr, status_wr;
    logic              load, halt, tick_clr, ovr_clr, stamp_ack;
    logic [CNT_W-1:0]  count;
    logic              running, expire;
    logic [TIME_W-1:0] time_now, stamp;
    logic              stamp_valid, overrun;
    logic [DATA_W-1:0] cnt_ext, reload_ext, status_word, ctrl_word;

    // Decode the register strobes.
    always_comb begin
        ctrl_wr   = wr_en && (addr == A_CTRL);
        status_wr = wr_en && (addr == A_STATUS);
        load      = ctrl_wr && wdata[CTRL_RUN_BIT];
        halt      = ctrl_wr && !wdata[CTRL_RUN_BIT];
        tick_clr  = status_wr && wdata[ST_TICK_BIT];
        ovr_clr   = status_wr && wdata[ST_OVR_BIT];
        stamp_ack = rd_en && (addr == A_STAMP_HI);
    end

    // Reload and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q   <= '0;
            periodic_q <= 1'b0;
        end else begin
            if (wr_en && addr == A_RELOAD) reload_q <= wdata[CNT_W-1:0];
            if (ctrl_wr) periodic_q <= wdata[CTRL_PER_BIT];
        end
    end

    // Sticky tick flag: set by expiry, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)        tick_q <= 1'b0;
        else if (expire)   tick_q <= 1'b1;
        else if (tick_clr) tick_q <= 1'b0;
    end

    assign irq_o = tick_q;

    tmr_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(load), .halt_i(halt),
        .periodic_i(periodic_q), .reload_i(reload_q),
        .count_o(count), .running_o(running), .expire_o(expire)
    );

    tmr_timebase #(.TIME_W(TIME_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .time_o(time_now)
    );

    tmr_evt_capture #(.TIME_W(TIME_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk(clk), .rst_n(rst_n), .evt_async_i(evt_i), .time_i(time_now),
        .ack_i(stamp_ack), .ovr_clr_i(ovr_clr),
        .stamp_o(stamp), .valid_o(stamp_valid), .overrun_o(overrun)
    );

    // Build read words from narrower fields.
    always_comb begin
        cnt_ext    = '0;
        cnt_ext[CNT_W-1:0] = count;
        reload_ext = '0;
        reload_ext[CNT_W-1:0] = reload_q;
        status_word = '0;
        status_word[ST_TICK_BIT]  = tick_q;
        status_word[ST_VALID_BIT] = stamp_valid;
        status_word[ST_OVR_BIT]   = overrun;
        status_word[ST_RUN_BIT]   = running;
        ctrl_word = '0;
        ctrl_word[CTRL_RUN_BIT] = running;
        ctrl_word[CTRL_PER_BIT] = periodic_q;
    end

    // Read multiplexer.
    always_comb begin
        unique case (addr)
            A_CTRL:     rdata = ctrl_word;
            A_RELOAD:   rdata = reload_ext;
            A_STATUS:   rdata = status_word;
            A_COUNT:    rdata = cnt_ext;
            A_STAMP_LO: rdata = stamp[DATA_W-1:0];
            A_STAMP_HI: rdata = stamp[TIME_W-1:DATA_W];
            A_TIME_LO:  rdata = time_now[DATA_W-1:0];
            default:    rdata = time_now[TIME_W-1:DATA_W];
        endcase
    end

    // R6: the tick flag is sticky until cleared with a one
    assert_tick_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q && !tick_clr |=> tick_q);
    // R6: an expiry always leaves the flag set
    assert_tick_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq_o);
endmodule

// File: tb/sim_interval_timer_ts.sv
module sim_interval_timer_ts;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        evt_i = 1'b0;
    logic        irq_o;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    interval_timer_ts u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_i(evt_i), .irq_o(irq_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic rd_ack(output logic [31:0] d);
        addr = 3'd5; rd_en = 1'b1; #1; d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check({31'd0, irq_o}, 32'd0, "R11 irq");
        rd(3'd0, v); check(v, 32'd0, "R11 ctrl");
        rd(3'd1, v); check(v, 32'd0, "R11 reload");
        rd(3'd2, v); check(v, 32'd0, "R11 status");
        rd(3'd3, v); check(v, 32'd0, "R11 count");
        rd(3'd7, v); check(v, 32'd0, "R11 time hi");
    endtask

    task automatic t_time;
        logic [31:0] a, b;
        rd(3'd6, a); edges(10); rd(3'd6, b);
        check(b - a, 32'd10, "R7 time step");
        rd(3'd7, b); check(b, 32'd0, "R7 time hi");
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr(3'd1, 32'd4);
        wr(3'd0, 32'h1);
        rd(3'd3, v); check(v, 32'd4, "R1 loaded count");
        edges(3); check({31'd0, irq_o}, 32'd0, "R1 no early tick");
        edges(1); check({31'd0, irq_o}, 32'd1, "R1 tick after N");
        rd(3'd3, v); check(v, 32'd0, "R2 stops at zero");
        rd(3'd2, v); check(v[3], 1'b0, "R2 running cleared");
        wr(3'd2, 32'h0);
        check({31'd0, irq_o}, 32'd1, "R6 write zero keeps flag");
        wr(3'd2, 32'h1);
        check({31'd0, irq_o}, 32'd0, "R6 write one clears");
        edges(20); check({31'd0, irq_o}, 32'd0, "R2 fires once");
    endtask

    task automatic t_periodic_halt;
        logic [31:0] a, b;
        wr(3'd1, 32'd5);
        wr(3'd0, 32'h3);
        edges(4); check({31'd0, irq_o}, 32'd0, "R3 no early tick");
        edges(1); check({31'd0, irq_o}, 32'd1, "R3 first tick");
        wr(3'd2, 32'h1);
        edges(3); check({31'd0, irq_o}, 32'd0, "R3 cleared between ticks");
        edges(1); check({31'd0, irq_o}, 32'd1, "R3 second tick");
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h1);
        rd(3'd3, a); edges(20); rd(3'd3, b);
        check(b, a, "R5 count frozen");
        check({31'd0, irq_o}, 32'd0, "R5 no tick when halted");
    endtask

    task automatic t_zero;
        logic [31:0] v;
        wr(3'd1, 32'd0);
        wr(3'd0, 32'h1);
        rd(3'd3, v); check(v, 32'hFFFF_FFFF, "R4 zero gives max");
        edges(3); rd(3'd3, v); check(v, 32'hFFFF_FFFC, "R4 counting from max");
        wr(3'd0, 32'h0);
    endtask

    task automatic t_event;
        logic [31:0] t0, v, s;
        rd(3'd6, t0); evt_i = 1'b1;
        edges(4);
        rd(3'd2, v); check(v[1], 1'b1, "R9 valid set");
        rd(3'd4, s); check(s, t0 + 32'd2, "R8 stamp value");
        edges(5);
        rd(3'd4, v); check(v, s, "R8 held level captures once");
        rd(3'd2, v); check(v[2], 1'b0, "R10 no overrun on level");
        rd_ack(v); check(v, 32'd0, "R8 stamp hi");
        rd(3'd2, v); check(v[1], 1'b0, "R9 valid cleared by read");
        evt_i = 1'b0; edges(3);
        rd(3'd6, t0); evt_i = 1'b1; edges(4);
        rd(3'd2, v); check(v[1], 1'b1, "R9 valid again");
        evt_i = 1'b0; edges(3);
        rd(3'd6, t0); evt_i = 1'b1; edges(4);
        rd(3'd2, v); check(v[2], 1'b1, "R10 overrun set");
        rd(3'd4, s); check(s, t0 + 32'd2, "R10 newest stamp kept");
        wr(3'd2, 32'h4);
        rd(3'd2, v); check(v[2], 1'b0, "R10 overrun cleared");
        evt_i = 1'b0;
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset;
        t_time;
        t_oneshot;
        t_periodic_halt;
        t_zero;
        t_event;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule